// File: doc/BRIEF.md
# Receive Frame Statistics Classifier

This block sits behind an Ethernet receive MAC and takes one summary per finished frame: the frame length counted with the FCS and without preamble or start delimiter, whether the FCS checked good, whether the frame carried a VLAN tag, the destination address, the length/type field, the number of data-plus-pad bytes actually received, the control opcode and the configured maximum payload length. From one summary it sorts the frame into several classes that may overlap. These are a size bin, the short and long error classes, the length-field error classes, the valid destination classes and the control classes.

Each class raises a one-cycle increment strobe one clock after the summary. A bank of wrapping counters, one per class, adds the strobes on the following clock. Every counter has a sticky overflow flag that is set when it wraps. A read port returns a counter's value and flag, and the read clears the flag.

Top module: `rx_frame_stats`

## Requirements
- R1: Every frame counts in exactly one size bin when its length is 64, 65..127, 128..255, 256..511, 512..1023 or 1024..1518 octets, regardless of FCS or length errors. A frame shorter than 64 or longer than 1518 counts in no bin.
- R2: A frame shorter than 64 octets counts as undersized when its FCS is good and as a fragment when its FCS is bad. It never counts as both.
- R3: A frame longer than 1518 octets with a good FCS counts as oversized. A frame longer than the parameter MTU_LEN with a bad FCS counts as a jabber.
- R4: A frame counts as long when its length exceeds the configured maximum payload plus 18, or plus 22 when tagged.
- R5: An in-range length error counts in two cases. In the first, the length/type value lies in min..1500 and differs from the received data count. In the second, the value is below min while the data count is above min. min is 46 untagged and 42 tagged.
- R6: A length/type value in 1501..1535 counts as an out-of-range length error.
- R7: A frame is valid when its FCS is good and it has no long, in-range or out-of-range error. A valid frame whose address is all ones counts as valid broadcast. A valid frame with bit 0 of the first octet set (address bit 40) that is not broadcast counts as valid multicast.
- R8: A frame with length/type 0x8808 is a control frame. It counts as pause when its opcode is 0x0001 and as unsupported control otherwise. No frame counts as both.
- R9: The total counter counts every summary. Strobes appear on `inc_o` one clock after the summary and are all zero in a cycle without a summary.
- R10: A counter adds one on the clock after its strobe and wraps at 2^CNT_W. The wrap sets the counter's sticky overflow flag. A read with `rd_en` high clears the flag on that clock, and a wrap on the same clock wins over the clear.
- R11: After reset every counter, flag and strobe is zero.
- R12: Read addresses are 0 total, 1..6 the size bins in ascending order, 7 undersized, 8 fragment, 9 oversized, 10 jabber, 11 long, 12 in-range error, 13 out-of-range error, 14 valid, 15 valid multicast, 16 valid broadcast, 17 pause and 18 unsupported control. The strobe bit index equals the address. Any other address reads zero with a clear flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sum_valid | input | 1 | Frame summary present this cycle |
| sum_len | input | LEN_W | Frame length including FCS |
| sum_fcs_ok | input | 1 | FCS checked good |
| sum_tagged | input | 1 | Frame carries a VLAN tag |
| sum_dst | input | 48 | Destination address, first octet in bits 47:40 |
| sum_lentype | input | 16 | Length/type field value |
| sum_paylen | input | 16 | Received data-plus-pad byte count |
| sum_opcode | input | 16 | Control opcode |
| cfg_max_pyld | input | LEN_W | Maximum payload length |
| inc_o | output | 19 | Per-class increment strobes |
| rd_en | input | 1 | Read strobe, clears the addressed flag |
| rd_addr | input | 5 | Counter address |
| rd_data | output | CNT_W | Addressed counter value |
| rd_ovf | output | 1 | Addressed counter overflow flag |

## Verification
The bench builds the block with CNT_W = 4, so a counter wraps after sixteen frames. This puts the wrap, the sticky flag, and a flag clear landing on the same clock as a wrap within a short run. MTU_LEN is set to 1600, which separates the jabber limit from the 1518 oversize limit so that R3 can be checked on both sides of each. The maximum payload is lowered at run time to move the long-frame limit into the small-frame range, tagged and untagged.

// File: rtl/rx_stats_pkg.sv
package rx_stats_pkg;
    localparam int NUM_CNT  = 19;
    localparam int ADDR_W   = 5;
    localparam int TYPE_W   = 16;
    localparam int NUM_BINS = 6;

    // counter / strobe indices (also read addresses)
    localparam int CI_TOTAL = 0;
    localparam int CI_BIN0  = 1;
    localparam int CI_UNDER = 7;
    localparam int CI_FRAG  = 8;
    localparam int CI_OVER  = 9;
    localparam int CI_JAB   = 10;
    localparam int CI_LONG  = 11;
    localparam int CI_INR   = 12;
    localparam int CI_OUTR  = 13;
    localparam int CI_VALID = 14;
    localparam int CI_VMC   = 15;
    localparam int CI_VBC   = 16;
    localparam int CI_PAUSE = 17;
    localparam int CI_UNSUP = 18;

    localparam int BIN_LO [NUM_BINS] = '{64, 65, 128, 256, 512, 1024};
    localparam int BIN_HI [NUM_BINS] = '{64, 127, 255, 511, 1023, 1518};

    localparam int STD_MIN       = 64;
    localparam int STD_MAX       = 1518;
    localparam int PAY_MIN_UNTAG = 46;
    localparam int PAY_MIN_TAG   = 42;
    localparam int LEN_FIELD_MAX = 1500;
    localparam int LEN_GAP_MAX   = 1535;
    localparam int OVH_UNTAG     = 18;
    localparam int OVH_TAG       = 22;
    localparam logic [TYPE_W-1:0] CTRL_TYPE = 16'h8808;
    localparam logic [TYPE_W-1:0] PAUSE_OP  = 16'h0001;

    typedef struct packed {
        logic [NUM_CNT-1:0] inc;
    } cls_state_t;
endpackage

// File: rtl/rx_frame_classifier.sv
module rx_frame_classifier
    import rx_stats_pkg::*;
#(
    parameter int LEN_W   = 16,
    parameter int DA_W    = 48,
    parameter int MTU_LEN = 1518
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sum_valid,
    input  logic [LEN_W-1:0]   sum_len,
    input  logic               sum_fcs_ok,
    input  logic               sum_tagged,
    input  logic [DA_W-1:0]    sum_dst,
    input  logic [TYPE_W-1:0]  sum_lentype,
    input  logic [TYPE_W-1:0]  sum_paylen,
    input  logic [TYPE_W-1:0]  sum_opcode,
    input  logic [LEN_W-1:0]   cfg_max_pyld,
    output logic [NUM_CNT-1:0] inc_o
);
    cls_state_t cls_d, cls_q;

    logic [NUM_BINS-1:0] bin_hit;
    logic                len_short, len_big, len_mtu;
    logic [LEN_W:0]      long_lim;
    logic                is_long;
    logic [TYPE_W-1:0]   pay_min;
    logic                inr_a, inr_b, in_rng, out_rng;
    logic                is_bcast, is_mcast, is_ctrl, is_pause, frame_good;

    for (genvar g = 0; g < NUM_BINS; g++) begin : g_bin
        assign bin_hit[g] = (sum_len >= LEN_W'(BIN_LO[g])) &&
                            (sum_len <= LEN_W'(BIN_HI[g]));
    end

    assign len_short = sum_len < LEN_W'(STD_MIN);
    assign len_big   = sum_len > LEN_W'(STD_MAX);
    assign len_mtu   = sum_len > LEN_W'(MTU_LEN);
    assign long_lim  = {1'b0, cfg_max_pyld} +
                       (sum_tagged ? (LEN_W+1)'(OVH_TAG) : (LEN_W+1)'(OVH_UNTAG));
    assign is_long   = {1'b0, sum_len} > long_lim;

    assign pay_min = sum_tagged ? TYPE_W'(PAY_MIN_TAG) : TYPE_W'(PAY_MIN_UNTAG);
    assign inr_a   = (sum_lentype >= pay_min) &&
                     (sum_lentype <= TYPE_W'(LEN_FIELD_MAX)) &&
                     (sum_lentype != sum_paylen);
    assign inr_b   = (sum_lentype < pay_min) && (sum_paylen > pay_min);
    assign in_rng  = inr_a || inr_b;
    assign out_rng = (sum_lentype > TYPE_W'(LEN_FIELD_MAX)) &&
                     (sum_lentype <= TYPE_W'(LEN_GAP_MAX));

    assign is_bcast   = &sum_dst;
    assign is_mcast   = sum_dst[DA_W-8] && !is_bcast;
    assign is_ctrl    = sum_lentype == CTRL_TYPE;
    assign is_pause   = is_ctrl && (sum_opcode == PAUSE_OP);
    assign frame_good = sum_fcs_ok && !is_long && !in_rng && !out_rng;

    always_comb begin
        cls_d = '0;
        if (sum_valid) begin
            cls_d.inc[CI_TOTAL]            = 1'b1;
            cls_d.inc[CI_BIN0 +: NUM_BINS] = bin_hit;
            cls_d.inc[CI_UNDER]            = len_short && sum_fcs_ok;
            cls_d.inc[CI_FRAG]             = len_short && !sum_fcs_ok;
            cls_d.inc[CI_OVER]             = len_big && sum_fcs_ok;
            cls_d.inc[CI_JAB]              = len_mtu && !sum_fcs_ok;
            cls_d.inc[CI_LONG]             = is_long;
            cls_d.inc[CI_INR]              = in_rng;
            cls_d.inc[CI_OUTR]             = out_rng;
            cls_d.inc[CI_VALID]            = frame_good;
            cls_d.inc[CI_VMC]              = frame_good && is_mcast;
            cls_d.inc[CI_VBC]              = frame_good && is_bcast;
            cls_d.inc[CI_PAUSE]            = is_pause;
            cls_d.inc[CI_UNSUP]            = is_ctrl && !is_pause;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cls_q <= '0;
        else        cls_q <= cls_d;
    end

    assign inc_o = cls_q.inc;

    // R1
    bin_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cls_q.inc[CI_BIN0 +: NUM_BINS]));
    // R2
    runt_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cls_q.inc[CI_UNDER] && cls_q.inc[CI_FRAG]));
    // R2
    undersize_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sum_valid && sum_fcs_ok && sum_len < LEN_W'(STD_MIN)) |=> cls_q.inc[CI_UNDER]);
    // R7
    dest_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cls_q.inc[CI_VMC] && cls_q.inc[CI_VBC]));
    // R7
    dest_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cls_q.inc[CI_VMC] || cls_q.inc[CI_VBC]) |-> cls_q.inc[CI_VALID]);
    // R8
    ctrl_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cls_q.inc[CI_PAUSE], cls_q.inc[CI_UNSUP]}));
    // R9
    total_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sum_valid |=> cls_q.inc[CI_TOTAL]);
    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sum_valid |=> (cls_q.inc == '0));
endmodule

// File: rtl/rx_stat_bank.sv
module rx_stat_bank
    import rx_stats_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CNT-1:0] inc_i,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [CNT_W-1:0]   rd_data,
    output logic               rd_ovf
);
    typedef struct packed {
        logic [NUM_CNT-1:0][CNT_W-1:0] cnt;
        logic [NUM_CNT-1:0]            ovf;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        for (int i = 0; i < NUM_CNT; i++) begin
            if (inc_i[i]) bank_d.cnt[i] = bank_q.cnt[i] + CNT_W'(1);
            if (rd_en && rd_addr == ADDR_W'(i)) bank_d.ovf[i] = 1'b0;
            if (inc_i[i] && bank_q.cnt[i] == '1) bank_d.ovf[i] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    always_comb begin
        rd_data = '0;
        rd_ovf  = 1'b0;
        for (int i = 0; i < NUM_CNT; i++) begin
            if (rd_addr == ADDR_W'(i)) begin
                rd_data = bank_q.cnt[i];
                rd_ovf  = bank_q.ovf[i];
            end
        end
    end

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_chk
        // R10
        cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
            inc_i[g] |=> bank_q.cnt[g] == $past(bank_q.cnt[g]) + CNT_W'(1));
        // R10
        cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !inc_i[g] |=> $stable(bank_q.cnt[g]));
        // R10
        no_overflow_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (inc_i[g] && bank_q.cnt[g] == '1) |=> bank_q.ovf[g]);
    end
endmodule

// File: rtl/rx_frame_stats.sv
module rx_frame_stats
    import rx_stats_pkg::*;
#(
    parameter int LEN_W   = 16,
    parameter int CNT_W   = 32,
    parameter int MTU_LEN = 1518
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sum_valid,
    input  logic [LEN_W-1:0]   sum_len,
    input  logic               sum_fcs_ok,
    input  logic               sum_tagged,
    input  logic [47:0]        sum_dst,
    input  logic [15:0]        sum_lentype,
    input  logic [15:0]        sum_paylen,
    input  logic [15:0]        sum_opcode,
    input  logic [LEN_W-1:0]   cfg_max_pyld,
    output logic [18:0]        inc_o,
    input  logic               rd_en,
    input  logic [4:0]         rd_addr,
    output logic [CNT_W-1:0]   rd_data,
    output logic               rd_ovf
);
    logic [NUM_CNT-1:0] inc_w;

    rx_frame_classifier #(
        .LEN_W  (LEN_W),
        .DA_W   (48),
        .MTU_LEN(MTU_LEN)
    ) u_cls (
        .clk         (clk),
        .rst_n       (rst_n),
        .sum_valid   (sum_valid),
        .sum_len     (sum_len),
        .sum_fcs_ok  (sum_fcs_ok),
        .sum_tagged  (sum_tagged),
        .sum_dst     (sum_dst),
        .sum_lentype (sum_lentype),
        .sum_paylen  (sum_paylen),
        .sum_opcode  (sum_opcode),
        .cfg_max_pyld(cfg_max_pyld),
        .inc_o       (inc_w)
    );

    rx_stat_bank #(
        .CNT_W(CNT_W)
    ) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc_i  (inc_w),
        .rd_en  (rd_en),
        .rd_addr(rd_addr),
        .rd_data(rd_data),
        .rd_ovf (rd_ovf)
    );

    assign inc_o = inc_w;
endmodule

// File: tb/rx_frame_stats_tb.sv
module rx_frame_stats_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 4;

    // indices taken from the read address map (R12)
    localparam int T_TOT = 0, T_B64 = 1, T_B65 = 2, T_B128 = 3, T_B256 = 4,
                   T_B512 = 5, T_B1024 = 6, T_UND = 7, T_FRG = 8, T_OVR = 9,
                   T_JAB = 10, T_LNG = 11, T_INR = 12, T_OUT = 13, T_VAL = 14,
                   T_VMC = 15, T_VBC = 16, T_PAU = 17, T_UNS = 18;

    localparam logic [47:0] DA_UC = 48'h0200_0000_0001;
    localparam logic [47:0] DA_MC = 48'h0100_5E00_0001;
    localparam logic [47:0] DA_BC = 48'hFFFF_FFFF_FFFF;

    logic clk = 1'b0;
    logic rst_n;
    logic sum_valid, sum_fcs_ok, sum_tagged, rd_en, rd_ovf;
    logic [15:0] sum_len, cfg_max_pyld, sum_lentype, sum_paylen, sum_opcode;
    logic [47:0] sum_dst;
    logic [18:0] inc_o;
    logic [4:0]  rd_addr;
    logic [CW-1:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_frame_stats #(.LEN_W(16), .CNT_W(CW), .MTU_LEN(1600)) u_dut (
        .clk(clk), .rst_n(rst_n), .sum_valid(sum_valid), .sum_len(sum_len),
        .sum_fcs_ok(sum_fcs_ok), .sum_tagged(sum_tagged), .sum_dst(sum_dst),
        .sum_lentype(sum_lentype), .sum_paylen(sum_paylen), .sum_opcode(sum_opcode),
        .cfg_max_pyld(cfg_max_pyld), .inc_o(inc_o), .rd_en(rd_en),
        .rd_addr(rd_addr), .rd_data(rd_data), .rd_ovf(rd_ovf)
    );

    function automatic logic [18:0] m(int i);
        return 19'(1) << i;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; sum_valid = 1'b0; rd_en = 1'b0; rd_addr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic drive(input int len, input bit fcs, input bit tag,
                         input logic [47:0] da, input int lt, input int pl, input int op);
        sum_valid = 1'b1; sum_len = 16'(len); sum_fcs_ok = fcs; sum_tagged = tag;
        sum_dst = da; sum_lentype = 16'(lt); sum_paylen = 16'(pl); sum_opcode = 16'(op);
    endtask

    task automatic frame_chk(input int len, input bit fcs, input bit tag,
                             input logic [47:0] da, input int lt, input int pl,
                             input int op, input logic [18:0] exp, input string req);
        @(negedge clk);
        drive(len, fcs, tag, da, lt, pl, op);
        @(negedge clk);
        sum_valid = 1'b0;
        check(inc_o === exp, req, $sformatf("strobes len=%0d lt=%0d", len, lt),
              32'(inc_o), 32'(exp));
    endtask

    task automatic burst(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            drive(64, 1'b1, 1'b0, DA_UC, 16'h0800, 0, 0);
        end
        @(negedge clk);
        sum_valid = 1'b0;
    endtask

    task automatic read_chk(input int a, input bit clr, input int exp_d,
                            input bit exp_o, input string req);
        @(negedge clk);
        rd_addr = 5'(a); rd_en = clr;
        #1;
        check(rd_data === CW'(exp_d), req, $sformatf("data addr=%0d", a),
              32'(rd_data), 32'(exp_d));
        check(rd_ovf === exp_o, req, $sformatf("ovf addr=%0d", a),
              32'(rd_ovf), 32'(exp_o));
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        @(negedge clk);
        check(inc_o === '0, "R11", "strobes after reset", 32'(inc_o), 0);
        read_chk(T_TOT, 1'b0, 0, 1'b0, "R11");
        read_chk(T_UNS, 1'b0, 0, 1'b0, "R11");
    endtask

    task automatic t_bins();
        logic [18:0] base = m(T_TOT) | m(T_VAL);
        frame_chk(64,   1, 0, DA_UC, 16'h0800, 0, 0, base | m(T_B64),   "R1");
        frame_chk(65,   1, 0, DA_UC, 16'h0800, 0, 0, base | m(T_B65),   "R1");
        frame_chk(127,  1, 0, DA_UC, 16'h0800, 0, 0, base | m(T_B65),   "R1");
        frame_chk(128,  1, 0, DA_UC, 16'h0800, 0, 0, base | m(T_B128),  "R1");
        frame_chk(255,  1, 0, DA_UC, 16'h0800, 0, 0, base | m(T_B128),  "R1");
        frame_chk(256,  1, 0, DA_UC, 16'h0800, 0, 0, base | m(T_B256),  "R1");
        frame_chk(511,  1, 0, DA_UC, 16'h0800, 0, 0, base | m(T_B256),  "R1");
        frame_chk(512,  1, 0, DA_UC, 16'h0800, 0, 0, base | m(T_B512),  "R1");
        frame_chk(1023, 1, 0, DA_UC, 16'h0800, 0, 0, base | m(T_B512),  "R1");
        frame_chk(1024, 1, 0, DA_UC, 16'h0800, 0, 0, base | m(T_B1024), "R1");
        frame_chk(1518, 1, 0, DA_UC, 16'h0800, 0, 0, base | m(T_B1024), "R3");
        frame_chk(300,  0, 0, DA_UC, 16'h0800, 0, 0, m(T_TOT) | m(T_B256), "R1");
    endtask

    task automatic t_short();
        frame_chk(63, 1, 0, DA_UC, 16'h0800, 0, 0, m(T_TOT) | m(T_UND) | m(T_VAL), "R2");
        frame_chk(40, 0, 0, DA_UC, 16'h0800, 0, 0, m(T_TOT) | m(T_FRG), "R2");
    endtask

    task automatic t_big();
        frame_chk(1519, 1, 0, DA_UC, 16'h0800, 0, 0, m(T_TOT) | m(T_OVR) | m(T_LNG), "R3");
        frame_chk(1522, 1, 1, DA_UC, 16'h0800, 0, 0, m(T_TOT) | m(T_OVR) | m(T_VAL), "R3");
        frame_chk(1523, 1, 1, DA_UC, 16'h0800, 0, 0, m(T_TOT) | m(T_OVR) | m(T_LNG), "R4");
        frame_chk(1600, 0, 0, DA_UC, 16'h0800, 0, 0, m(T_TOT) | m(T_LNG), "R3");
        frame_chk(1601, 0, 0, DA_UC, 16'h0800, 0, 0, m(T_TOT) | m(T_JAB) | m(T_LNG), "R3");
    endtask

    task automatic t_long();
        cfg_max_pyld = 16'd100;
        frame_chk(118, 1, 0, DA_UC, 16'h0800, 0, 0, m(T_TOT) | m(T_B65) | m(T_VAL), "R4");
        frame_chk(119, 1, 0, DA_UC, 16'h0800, 0, 0, m(T_TOT) | m(T_B65) | m(T_LNG), "R4");
        frame_chk(122, 1, 1, DA_UC, 16'h0800, 0, 0, m(T_TOT) | m(T_B65) | m(T_VAL), "R4");
        frame_chk(123, 1, 1, DA_UC, 16'h0800, 0, 0, m(T_TOT) | m(T_B65) | m(T_LNG), "R4");
        cfg_max_pyld = 16'd1500;
    endtask

    task automatic t_lenerr();
        logic [18:0] ok  = m(T_TOT) | m(T_B65) | m(T_VAL);
        logic [18:0] inr = m(T_TOT) | m(T_B65) | m(T_INR);
        logic [18:0] otr = m(T_TOT) | m(T_B65) | m(T_OUT);
        frame_chk(100, 1, 0, DA_UC, 100,  100,  0, ok,  "R5");
        frame_chk(100, 1, 0, DA_UC, 100,  90,   0, inr, "R5");
        frame_chk(100, 1, 0, DA_UC, 46,   47,   0, inr, "R5");
        frame_chk(100, 1, 0, DA_UC, 45,   46,   0, ok,  "R5");
        frame_chk(100, 1, 0, DA_UC, 45,   47,   0, inr, "R5");
        frame_chk(100, 1, 1, DA_UC, 42,   42,   0, ok,  "R5");
        frame_chk(100, 1, 1, DA_UC, 41,   43,   0, inr, "R5");
        frame_chk(100, 1, 1, DA_UC, 41,   42,   0, ok,  "R5");
        frame_chk(100, 1, 0, DA_UC, 1500, 1500, 0, ok,  "R5");
        frame_chk(100, 1, 0, DA_UC, 1501, 0,    0, otr, "R6");
        frame_chk(100, 1, 0, DA_UC, 1535, 0,    0, otr, "R6");
        frame_chk(100, 1, 0, DA_UC, 1536, 0,    0, ok,  "R6");
    endtask

    task automatic t_addr();
        logic [18:0] b = m(T_TOT) | m(T_B64);
        frame_chk(64, 1, 0, DA_BC, 16'h0800, 0,  0, b | m(T_VAL) | m(T_VBC), "R7");
        frame_chk(64, 1, 0, DA_MC, 16'h0800, 0,  0, b | m(T_VAL) | m(T_VMC), "R7");
        frame_chk(64, 0, 0, DA_MC, 16'h0800, 0,  0, b, "R7");
        frame_chk(64, 1, 0, DA_BC, 100,      90, 0, b | m(T_INR), "R7");
    endtask

    task automatic t_ctrl();
        logic [18:0] b = m(T_TOT) | m(T_B64);
        frame_chk(64, 1, 0, DA_MC, 16'h8808, 0, 16'h0001, b | m(T_VAL) | m(T_VMC) | m(T_PAU), "R8");
        frame_chk(64, 1, 0, DA_UC, 16'h8808, 0, 16'h0002, b | m(T_VAL) | m(T_UNS), "R8");
        frame_chk(64, 0, 0, DA_UC, 16'h8808, 0, 16'h0001, b | m(T_PAU), "R8");
        frame_chk(64, 1, 0, DA_UC, 16'h8808, 0, 16'h0100, b | m(T_VAL) | m(T_UNS), "R8");
        @(negedge clk);
        check(inc_o === '0, "R9", "idle strobes", 32'(inc_o), 0);
    endtask

    task automatic t_counters();
        do_reset();
        read_chk(T_B64, 1'b0, 0, 1'b0, "R11");
        burst(3);
        read_chk(T_B64, 1'b0, 3, 1'b0, "R10");
        read_chk(T_TOT, 1'b0, 3, 1'b0, "R9");
        read_chk(T_UND, 1'b0, 0, 1'b0, "R10");
        read_chk(25,    1'b0, 0, 1'b0, "R12");
        burst(13);
        read_chk(T_B64, 1'b1, 0, 1'b1, "R10");
        read_chk(T_B64, 1'b0, 0, 1'b0, "R10");
        read_chk(T_TOT, 1'b0, 0, 1'b1, "R10");
        burst(15);
        read_chk(T_B64, 1'b0, 15, 1'b0, "R10");
        @(negedge clk);
        drive(64, 1'b1, 1'b0, DA_UC, 16'h0800, 0, 0);
        @(negedge clk);
        sum_valid = 1'b0; rd_addr = 5'(T_B64); rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        #1;
        check(rd_ovf === 1'b1, "R10", "wrap beats clear", 32'(rd_ovf), 1);
        check(rd_data === '0, "R10", "wrapped value", 32'(rd_data), 0);
    endtask

    initial begin
        rst_n = 1'b0; sum_valid = 1'b0; rd_en = 1'b0; rd_addr = '0;
        sum_len = '0; sum_fcs_ok = 1'b0; sum_tagged = 1'b0; sum_dst = '0;
        sum_lentype = '0; sum_paylen = '0; sum_opcode = '0; cfg_max_pyld = 16'd1500;
        t_reset();
        t_bins();
        t_short();
        t_big();
        t_long();
        t_lenerr();
        t_addr();
        t_ctrl();
        t_counters();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule